// File: doc/BRIEF.md
# Tag Command Access Controller

This block carries out the downlink commands of a passive read/write identification tag. The tag stores 32 words of 32 bits, and a serial front end that sits outside this block turns the reader's modulated field into decoded items. Each command or address arrives as a 9-bit block (eight data bits and one even-parity bit), and each payload arrives as a 32-bit word. Every item comes with a flag that says whether its parity checked out. The controller decodes the command and checks the password. It keeps the login state and applies the write policy for each address. It then answers with one-cycle ACK or NAK pulses.

Word 0 of the store holds the password, word 1 the protection ranges and word 2 the control settings. The ranges and settings in use are copies of words 1 and 2. These copies are taken at power-up and on the reset command, so a write to word 1 or 2 changes nothing until the next reload. A successful write gives two ACKs: one when the request is accepted and one when the store has been programmed. Between them a busy interval of carrier clocks runs, and its length depends on the bit-period option. The controller also hands two things to the read sequencer that sits next to it: a one-pass override range for selective reads, and a read-after-write request.

Top module: `tag_cmd_ctrl`

## Requirements
- R1: A block received while idle is taken as a command. The 9 bits are held in `blk_bits[8:0]`, with bit 8 received first and bit 0 the parity bit. The codes are: login 000000011, write-password 000100010, write-word 000100100, selective-read 000010100, reset 100000001. An unknown code, or a block whose `blk_par_ok` is low, gives NAK.
- R2: ACK and NAK are one-cycle pulses and never occur together. An answer to an input appears in the cycle after that input is sampled.
- R3: Login compares the next word with the stored password. A match with good parity gives ACK and sets `logged_in`. A mismatch gives NAK and clears `logged_in`. The login state then persists across later commands.
- R4: The reset command gives ACK and clears `logged_in`. One cycle later it reloads the protection word (read-protect range in bits 0–7 and 8–15, write-inhibit range in bits 16–23 and 24–31) and the control word (standard read range in bits 0–7 and 8–15, password check in bit 16, read-after-write in bit 17) onto `rp_*` and `std_*`. After power-on, `logged_in` is low and the active settings come from the stored words.
- R5: In the write-word address block, data bits `blk_bits[8:1]` form a byte with its MSB received first. Bits 7 to 5 of this byte must be zero: bit 5 set would address the ROM words. Bits 4 to 0 select the word. Any other address gives NAK after the data word.
- R6: Word 0 can never be written with write-word. Words 1 and 2 need a login and must lie outside the active write-inhibit range.
- R7: Words 3–31 are refused inside the inhibit range. Outside it they are written freely when the password check is off, and only after a login when it is on.
- R8: A write-word whose data parity, power flag, address and policy all pass gives ACK. Exactly 3200 cycles later it gives a second ACK together with an `ee_we` pulse, `ee_addr` and `ee_wdata`. Any failed check gives NAK and nothing is written.
- R9: Write-password gives ACK when the current password matches. It then takes the new word: good parity gives ACK, and 3200 cycles later a second ACK stores the word at address 0. A mismatch or bad parity gives NAK and keeps the old password.
- R10: Selective-read gives ACK and a `sel_vld` pulse that carries word bits 0–7 as the first address and bits 8–15 as the last address. Bits 16–31 are ignored. Bad parity gives NAK and no `sel_vld`.
- R11: `raw_req` pulses with the second ACK of a write-word when active control bit 17 is set. It never pulses for a password write.
- R12: A write to word 1 or 2 leaves `std_*`, `rp_*` and the write policy unchanged until the next reset.
- R13: While a word is awaited, a block gives NAK. While an address block is awaited, a word gives NAK. A word received while idle gets no answer.
- R14: `rd_data` returns the stored word at `rd_addr` in the same cycle. Address 0 always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_vld | input | 1 | A 9-bit block is present |
| blk_bits | input | 9 | Block bits, bit 8 received first, bit 0 parity |
| blk_par_ok | input | 1 | Block parity checked good |
| wrd_vld | input | 1 | A 32-bit word is present |
| wrd_data | input | 32 | Decoded word |
| wrd_par_ok | input | 1 | Row and column parity of the word good |
| pwr_ok | input | 1 | Field strong enough to program |
| rd_addr | input | 5 | Read address of the store |
| rd_data | output | 32 | Stored word, zero for address 0 |
| ack | output | 1 | Acknowledge pulse |
| nak | output | 1 | Refusal pulse |
| logged_in | output | 1 | Password accepted since the last reset |
| ee_we | output | 1 | Store programmed this cycle |
| ee_addr | output | 5 | Programmed address |
| ee_wdata | output | 32 | Programmed data |
| sel_vld | output | 1 | Selective-read override pulse |
| sel_first | output | 8 | Override first address |
| sel_last | output | 8 | Override last address |
| raw_req | output | 1 | Read-after-write request pulse |
| std_first | output | 8 | Active standard first read address |
| std_last | output | 8 | Active standard last read address |
| rp_first | output | 8 | Active first read-protected word |
| rp_last | output | 8 | Active last read-protected word |

## Verification
Each input is held for one cycle, driven on a falling edge. The ACK or NAK for it is read on the next falling edge, one register after the edge that sampled the input. The second ACK of a write, with `ee_we`, `ee_addr`, `ee_wdata` and `raw_req`, is due exactly 3200 cycles after the first ACK. The bench counts falling edges from the first ACK and expects the pulse on the 3200th. The reloaded `std_*` and `rp_*` values are due one cycle after the ACK of the reset command and are read one falling edge later. `rd_data` is combinational and is checked in the same cycle that `rd_addr` is set.

// File: rtl/tag_cmd_pkg.sv
package tag_cmd_pkg;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOGIN,
    ST_PW_OLD,
    ST_PW_NEW,
    ST_WW_ADDR,
    ST_WW_DATA,
    ST_SEL,
    ST_BUSY
  } cmd_state_e;

  // Command blocks, bit 8 received first, bit 0 is the even-parity bit
  localparam logic [8:0] OP_LOGIN = 9'b000000011;
  localparam logic [8:0] OP_WRPW  = 9'b000100010;
  localparam logic [8:0] OP_WRWD  = 9'b000100100;
  localparam logic [8:0] OP_SELRD = 9'b000010100;
  localparam logic [8:0] OP_RESET = 9'b100000001;

  localparam int CTRL_W   = 18;
  localparam int CHK_BIT  = 16;
  localparam int RAW_BIT  = 17;

endpackage

// File: rtl/tag_word_store.sv
module tag_word_store #(
  parameter int W       = 32,
  parameter int N_WORDS = 32,
  parameter int CTRL_W  = 18,
  localparam int AW     = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [W-1:0]      wdata,
  input  logic [AW-1:0]     raddr,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      pw_o,
  output logic [W-1:0]      prot_o,
  output logic [CTRL_W-1:0] ctrl_o
);

  logic [W-1:0] mem_q [N_WORDS];

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    logic hit;
    assign hit = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[i] <= '0;
      else if (hit) mem_q[i] <= wdata;
    end
  end

  // the password word is never readable
  assign rdata  = (raddr == '0) ? '0 : mem_q[raddr];
  assign pw_o   = mem_q[0];
  assign prot_o = mem_q[1];
  assign ctrl_o = mem_q[2][CTRL_W-1:0];

endmodule

// File: rtl/tag_wr_policy.sv
module tag_wr_policy #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] waddr,
  input  logic          logged_in,
  input  logic          chk_en,
  input  logic [7:0]    inh_first,
  input  logic [7:0]    inh_last,
  output logic          allow
);

  logic [7:0] a8;
  logic       inhibited;

  assign a8        = 8'(waddr);
  assign inhibited = (a8 >= inh_first) && (a8 <= inh_last);

  always_comb begin
    if (a8 == 8'd0)      allow = 1'b0;
    else if (a8 <= 8'd2) allow = logged_in && !inhibited;
    else                 allow = !inhibited && (!chk_en || logged_in);
  end

endmodule

// File: rtl/tag_busy_timer.sv
module tag_busy_timer #(
  parameter int CYCLES = 3200,
  localparam int CW    = $clog2(CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == CW'(CYCLES - 1));

endmodule

// File: rtl/tag_cmd_ctrl.sv
module tag_cmd_ctrl
  import tag_cmd_pkg::*;
#(
  parameter int W        = 32,
  parameter int N_WORDS  = 32,
  parameter int BIT_CLKS = 64,
  localparam int AW      = $clog2(N_WORDS),
  localparam int EE_CYC  = (BIT_CLKS == 64) ? 3200 : 2624
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_vld,
  input  logic [8:0]    blk_bits,
  input  logic          blk_par_ok,
  input  logic          wrd_vld,
  input  logic [W-1:0]  wrd_data,
  input  logic          wrd_par_ok,
  input  logic          pwr_ok,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          ack,
  output logic          nak,
  output logic          logged_in,
  output logic          ee_we,
  output logic [AW-1:0] ee_addr,
  output logic [W-1:0]  ee_wdata,
  output logic          sel_vld,
  output logic [7:0]    sel_first,
  output logic [7:0]    sel_last,
  output logic          raw_req,
  output logic [7:0]    std_first,
  output logic [7:0]    std_last,
  output logic [7:0]    rp_first,
  output logic [7:0]    rp_last
);

  cmd_state_e        state_q, state_d;
  logic              login_q, login_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic              aok_q, aok_d;
  logic [W-1:0]      wdat_q, wdat_d;
  logic              pwwr_q, pwwr_d;
  logic [W-1:0]      prot_q, prot_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ack_q, ack_d, nak_q, nak_d, we_q, we_d;
  logic              sel_q, sel_d, raw_q, raw_d;
  logic [7:0]        self_q, self_d, sell_q, sell_d;

  logic [W-1:0]      st_pw, st_prot;
  logic [CTRL_W-1:0] st_ctrl;
  logic              allow, done;
  logic              wrd_ok;

  tag_word_store #(.W(W), .N_WORDS(N_WORDS), .CTRL_W(CTRL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we_d), .waddr(addr_q), .wdata(wdat_q),
    .raddr(rd_addr), .rdata(rd_data),
    .pw_o(st_pw), .prot_o(st_prot), .ctrl_o(st_ctrl)
  );

  tag_wr_policy #(.AW(AW)) u_policy (
    .waddr(addr_q), .logged_in(login_q), .chk_en(ctrl_q[CHK_BIT]),
    .inh_first(prot_q[23:16]), .inh_last(prot_q[31:24]), .allow(allow)
  );

  tag_busy_timer #(.CYCLES(EE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_BUSY), .done(done)
  );

  assign wrd_ok = wrd_vld && wrd_par_ok;

  always_comb begin
    state_d = state_q;  login_d = login_q;  addr_d = addr_q;  aok_d = aok_q;
    wdat_d  = wdat_q;   pwwr_d  = pwwr_q;   prot_d = prot_q;  ctrl_d = ctrl_q;
    self_d  = self_q;   sell_d  = sell_q;
    ack_d = 1'b0; nak_d = 1'b0; we_d = 1'b0; sel_d = 1'b0; raw_d = 1'b0;
    unique case (state_q)
      ST_INIT: begin
        prot_d  = st_prot;
        ctrl_d  = st_ctrl;
        state_d = ST_IDLE;
      end
      ST_IDLE: if (blk_vld) begin
        if (!blk_par_ok) nak_d = 1'b1;
        else begin
          unique case (blk_bits)
            OP_LOGIN: state_d = ST_LOGIN;
            OP_WRPW:  state_d = ST_PW_OLD;
            OP_WRWD:  state_d = ST_WW_ADDR;
            OP_SELRD: state_d = ST_SEL;
            OP_RESET: begin ack_d = 1'b1; login_d = 1'b0; state_d = ST_INIT; end
            default:  nak_d = 1'b1;
          endcase
        end
      end
      ST_LOGIN: if (blk_vld) begin
        nak_d = 1'b1; state_d = ST_IDLE;
      end else if (wrd_vld) begin
        login_d = wrd_ok && (wrd_data == st_pw);
        ack_d   = login_d;
        nak_d   = !login_d;
        state_d = ST_IDLE;
      end
      ST_PW_OLD: if (blk_vld) begin
        nak_d = 1'b1; state_d = ST_IDLE;
      end else if (wrd_vld) begin
        if (wrd_ok && (wrd_data == st_pw)) begin ack_d = 1'b1; state_d = ST_PW_NEW; end
        else begin nak_d = 1'b1; state_d = ST_IDLE; end
      end
      ST_PW_NEW: if (blk_vld) begin
        nak_d = 1'b1; state_d = ST_IDLE;
      end else if (wrd_vld) begin
        if (wrd_ok) begin
          ack_d = 1'b1; wdat_d = wrd_data; addr_d = '0; pwwr_d = 1'b1; state_d = ST_BUSY;
        end else begin
          nak_d = 1'b1; state_d = ST_IDLE;
        end
      end
      ST_WW_ADDR: if (wrd_vld) begin
        nak_d = 1'b1; state_d = ST_IDLE;
      end else if (blk_vld) begin
        if (blk_par_ok) begin
          addr_d  = blk_bits[AW:1];
          aok_d   = (blk_bits[8:AW+1] == '0);
          state_d = ST_WW_DATA;
        end else begin
          nak_d = 1'b1; state_d = ST_IDLE;
        end
      end
      ST_WW_DATA: if (blk_vld) begin
        nak_d = 1'b1; state_d = ST_IDLE;
      end else if (wrd_vld) begin
        if (wrd_ok && aok_q && allow && pwr_ok) begin
          ack_d = 1'b1; wdat_d = wrd_data; pwwr_d = 1'b0; state_d = ST_BUSY;
        end else begin
          nak_d = 1'b1; state_d = ST_IDLE;
        end
      end
      ST_SEL: if (blk_vld) begin
        nak_d = 1'b1; state_d = ST_IDLE;
      end else if (wrd_vld) begin
        if (wrd_par_ok) begin
          ack_d = 1'b1; sel_d = 1'b1;
          self_d = wrd_data[7:0]; sell_d = wrd_data[15:8];
        end else nak_d = 1'b1;
        state_d = ST_IDLE;
      end
      ST_BUSY: if (done) begin
        ack_d = 1'b1; we_d = 1'b1;
        raw_d = !pwwr_q && ctrl_q[RAW_BIT];
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT; login_q <= 1'b0; addr_q <= '0; aok_q <= 1'b0;
      wdat_q  <= '0;      pwwr_q  <= 1'b0; prot_q <= '0; ctrl_q <= '0;
      ack_q   <= 1'b0;    nak_q   <= 1'b0; we_q   <= 1'b0;
      sel_q   <= 1'b0;    raw_q   <= 1'b0; self_q <= '0; sell_q <= '0;
    end else begin
      state_q <= state_d; login_q <= login_d; addr_q <= addr_d; aok_q <= aok_d;
      wdat_q  <= wdat_d;  pwwr_q  <= pwwr_d;  prot_q <= prot_d; ctrl_q <= ctrl_d;
      ack_q   <= ack_d;   nak_q   <= nak_d;   we_q   <= we_d;
      sel_q   <= sel_d;   raw_q   <= raw_d;   self_q <= self_d; sell_q <= sell_d;
    end
  end

  assign ack       = ack_q;
  assign nak       = nak_q;
  assign logged_in = login_q;
  assign ee_we     = we_q;
  assign ee_addr   = addr_q;
  assign ee_wdata  = wdat_q;
  assign sel_vld   = sel_q;
  assign sel_first = self_q;
  assign sel_last  = sell_q;
  assign raw_req   = raw_q;
  assign std_first = ctrl_q[7:0];
  assign std_last  = ctrl_q[15:8];
  assign rp_first  = prot_q[7:0];
  assign rp_last   = prot_q[15:8];

endmodule

// File: rtl/tag_cmd_ctrl_chk.sv
module tag_cmd_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          nak,
  input logic          logged_in,
  input logic          ee_we,
  input logic [AW-1:0] ee_addr,
  input logic          sel_vld,
  input logic          raw_req,
  input logic [7:0]    std_first
);

  // R2
  ack_nak_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack, nak}));

  // R8
  we_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_we |-> ack);

  // R8
  we_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_we |-> $past(!ack && !nak));

  // R10
  sel_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |-> ack);

  // R11
  raw_on_word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_req |-> (ee_we && ee_addr != '0));

  // R3
  login_rise_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(logged_in) |-> ack);

  // R12
  std_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(std_first) |-> $past(ack));

endmodule

bind tag_cmd_ctrl tag_cmd_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .nak(nak), .logged_in(logged_in),
  .ee_we(ee_we), .ee_addr(ee_addr), .sel_vld(sel_vld), .raw_req(raw_req),
  .std_first(std_first)
);

// File: tb/test_tag_cmd_ctrl.sv
module test_tag_cmd_ctrl;
  localparam int EE = 3200;
  localparam logic [8:0] C_LOGIN = 9'b000000011;
  localparam logic [8:0] C_WRPW  = 9'b000100010;
  localparam logic [8:0] C_WRWD  = 9'b000100100;
  localparam logic [8:0] C_SELRD = 9'b000010100;
  localparam logic [8:0] C_RESET = 9'b100000001;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, blk_vld, blk_par_ok, wrd_vld, wrd_par_ok, pwr_ok;
  logic [8:0] blk_bits;
  logic [31:0] wrd_data, rd_data, ee_wdata;
  logic [4:0] rd_addr, ee_addr;
  logic ack, nak, logged_in, ee_we, sel_vld, raw_req;
  logic [7:0] sel_first, sel_last, std_first, std_last, rp_first, rp_last;

  tag_cmd_ctrl i_tag_cmd_ctrl (.*);

  logic [31:0] mem_m [32];
  logic [31:0] prot_m, ctrl_m;
  bit login_m;
  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] mkblk(input logic [7:0] b);
    return {b, ^b};
  endfunction

  function automatic bit allowed(input logic [4:0] a);
    bit inh;
    inh = (8'(a) >= prot_m[23:16]) && (8'(a) <= prot_m[31:24]);
    if (a == 0) return 1'b0;
    if (a <= 2) return login_m && !inh;
    return !inh && (!ctrl_m[16] || login_m);
  endfunction

  task automatic put_blk(input logic [8:0] b, input bit pok, output bit a, output bit n);
    @(negedge clk); blk_vld = 1'b1; blk_bits = b; blk_par_ok = pok;
    @(negedge clk); blk_vld = 1'b0; a = ack; n = nak;
  endtask

  task automatic put_wrd(input logic [31:0] d, input bit pok, output bit a, output bit n);
    @(negedge clk); wrd_vld = 1'b1; wrd_data = d; wrd_par_ok = pok;
    @(negedge clk); wrd_vld = 1'b0; a = ack; n = nak;
  endtask

  task automatic wait_done(output int dly, output bit w, output logic [4:0] ad,
                           output logic [31:0] dt, output bit rq);
    dly = -1; w = 0; ad = 0; dt = 0; rq = 0;
    for (int i = 1; i <= EE + 4 && dly < 0; i++) begin
      @(negedge clk);
      if (ack) begin dly = i; w = ee_we; ad = ee_addr; dt = ee_wdata; rq = raw_req; end
    end
  endtask

  task automatic do_ww(input logic [7:0] byt, input logic [31:0] d, input bit dok,
                       input bit pw, input string req);
    bit a, n, w, rq, exp; int dly; logic [4:0] ad; logic [31:0] dt;
    put_blk(C_WRWD, 1'b1, a, n);
    chk(!a && !n, req, {a, n}, 0);
    put_blk(mkblk(byt), 1'b1, a, n);
    pwr_ok = pw;
    put_wrd(d, dok, a, n);
    pwr_ok = 1'b1;
    exp = dok && pw && (byt[7:5] == 0) && allowed(byt[4:0]);
    chk(a == exp && n == !exp, req, {a, n}, {exp, !exp});
    if (exp) begin
      wait_done(dly, w, ad, dt, rq);
      chk(dly == EE && w, "R8", dly, EE);
      chk(ad == byt[4:0] && dt == d, "R8", {ad, dt}, {byt[4:0], d});
      chk(rq == ctrl_m[17], "R11", rq, ctrl_m[17]);
      mem_m[byt[4:0]] = d;
      rd_addr = byt[4:0]; #1;
      chk(rd_data == d, "R14", rd_data, d);
    end
  endtask

  task automatic do_login(input logic [31:0] pw);
    bit a, n, exp;
    put_blk(C_LOGIN, 1'b1, a, n);
    put_wrd(pw, 1'b1, a, n);
    exp = (pw == mem_m[0]);
    login_m = exp;
    chk(a == exp && n == !exp && logged_in == exp, "R3", {a, n, logged_in}, {exp, !exp, exp});
  endtask

  task automatic do_reset();
    bit a, n;
    put_blk(C_RESET, 1'b1, a, n);
    login_m = 0; prot_m = mem_m[1]; ctrl_m = mem_m[2];
    chk(a && !n && !logged_in, "R4", {a, n, logged_in}, 3'b100);
    @(negedge clk);
    chk(std_first == ctrl_m[7:0] && std_last == ctrl_m[15:8], "R4",
        {std_first, std_last}, {ctrl_m[7:0], ctrl_m[15:8]});
    chk(rp_first == prot_m[7:0] && rp_last == prot_m[15:8], "R4",
        {rp_first, rp_last}, {prot_m[7:0], prot_m[15:8]});
  endtask

  task automatic do_sel(input logic [31:0] d, input bit ok);
    bit a, n;
    put_blk(C_SELRD, 1'b1, a, n);
    put_wrd(d, ok, a, n);
    chk(a == ok && n == !ok && sel_vld == ok, "R10", {a, n, sel_vld}, {ok, !ok, ok});
    if (ok) chk(sel_first == d[7:0] && sel_last == d[15:8], "R10",
                {sel_first, sel_last}, d[15:0]);
  endtask

  task automatic do_wpw(input logic [31:0] old_pw, input logic [31:0] new_pw, input bit nok);
    bit a, n, w, rq, e1; int dly; logic [4:0] ad; logic [31:0] dt;
    put_blk(C_WRPW, 1'b1, a, n);
    put_wrd(old_pw, 1'b1, a, n);
    e1 = (old_pw == mem_m[0]);
    chk(a == e1 && n == !e1, "R9", {a, n}, {e1, !e1});
    if (e1) begin
      put_wrd(new_pw, nok, a, n);
      chk(a == nok && n == !nok, "R9", {a, n}, {nok, !nok});
      if (nok) begin
        wait_done(dly, w, ad, dt, rq);
        chk(dly == EE && w && ad == 0 && dt == new_pw, "R9", {dly, ad, dt}, {EE, 5'd0, new_pw});
        chk(!rq, "R11", rq, 0);
        mem_m[0] = new_pw;
        rd_addr = 0; #1;
        chk(rd_data == 0, "R14", rd_data, 0);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    bit a, n;
    void'($urandom(32'h1d5a));
    for (int i = 0; i < 32; i++) mem_m[i] = 0;
    prot_m = 0; ctrl_m = 0; login_m = 0;
    rst_n = 0; blk_vld = 0; blk_bits = 0; blk_par_ok = 0;
    wrd_vld = 0; wrd_data = 0; wrd_par_ok = 0; pwr_ok = 1; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 power-on state
    chk(!logged_in && !ack && !nak && std_first == 0 && std_last == 0, "R4",
        {logged_in, ack, nak, std_first, std_last}, 0);

    // R1 bad parity and unknown code
    put_blk(C_LOGIN, 1'b0, a, n); chk(!a && n, "R1", {a, n}, 2'b01);
    put_blk(9'h0FF, 1'b1, a, n);  chk(!a && n, "R1", {a, n}, 2'b01);
    // R13 word in idle is ignored, block while awaiting a word is refused
    put_wrd(32'h1234, 1'b1, a, n); chk(!a && !n, "R13", {a, n}, 0);
    put_blk(C_LOGIN, 1'b1, a, n);
    put_blk(C_RESET, 1'b1, a, n); chk(!a && n, "R13", {a, n}, 2'b01);

    do_ww(8'd5, 32'hCAFE0005, 1, 1, "R7");   // check off, free write
    do_ww(8'd1, 32'h0, 1, 1, "R6");          // no login
    do_ww(8'd0, 32'h0, 1, 1, "R6");          // password word
    do_login(32'h1);
    do_login(32'h0);
    do_ww(8'd0, 32'h0, 1, 1, "R6");          // still refused with login
    do_ww(8'd1, {8'd12, 8'd10, 8'd20, 8'd16}, 1, 1, "R6");
    do_ww(8'd2, {14'd0, 1'b1, 1'b1, 8'd7, 8'd4}, 1, 1, "R6");
    chk(std_first == 0 && rp_first == 0, "R12", {std_first, rp_first}, 0);
    do_ww(8'd11, 32'h0B0B, 1, 1, "R12");     // old inhibit range still active
    do_reset();
    do_ww(8'd11, 32'h1111, 1, 1, "R7");      // inhibited
    do_ww(8'd5, 32'h5555, 1, 1, "R7");       // check on, no login
    do_login(32'h0);
    do_ww(8'd11, 32'h1111, 1, 1, "R7");
    do_ww(8'd5, 32'h5555, 1, 1, "R11");      // read-after-write on
    do_ww(8'h45, 32'h1, 1, 1, "R5");
    do_ww(8'h21, 32'h1, 1, 1, "R5");
    do_ww(8'd6, 32'h1, 1, 0, "R8");          // weak field
    do_ww(8'd6, 32'h1, 0, 1, "R8");          // data parity
    put_blk(C_WRWD, 1'b1, a, n);
    put_wrd(32'h9, 1'b1, a, n); chk(!a && n, "R13", {a, n}, 2'b01);
    do_sel(32'hBEEF_0903, 1);
    do_sel(32'h0000_0903, 0);
    do_wpw(32'h7, 32'h0, 1);
    do_wpw(32'h0, 32'hA5A5_0001, 0);
    do_wpw(32'h0, 32'hA5A5_0001, 1);
    do_login(32'h0);
    do_login(32'hA5A5_0001);

    for (int it = 0; it < 36; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 3) begin
        int ad;
        logic [7:0] byt;
        ad = $urandom_range(0, 47);
        if (ad == 1 || ad == 2) ad = 3;
        byt = 8'(ad);
        if ($urandom_range(0, 7) == 0) byt = byt | 8'h40;
        do_ww(byt, $urandom, $urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0, "R7");
      end else if (op <= 5) begin
        do_login($urandom_range(0, 1) ? mem_m[0] : $urandom);
      end else if (op == 6) begin
        do_sel($urandom, $urandom_range(0, 3) != 0);
      end else if (op == 7) begin
        do_reset();
      end else if (op == 8) begin
        logic [8:0] c;
        do c = 9'($urandom_range(0, 511));
        while (c inside {C_LOGIN, C_WRPW, C_WRWD, C_SELRD, C_RESET});
        put_blk(c, 1'b1, a, n); chk(!a && n, "R1", {a, n}, 2'b01);
      end else begin
        do_wpw($urandom_range(0, 3) != 0 ? mem_m[0] : $urandom, $urandom, 1);
      end
      chk(logged_in == login_m, "R3", logged_in, login_m);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule